// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block runs the receive side of a descriptor-driven network controller. The host keeps a ring of 16-byte descriptors in its memory. Each descriptor names a data buffer and its length, and carries a flag that says whether the controller now owns it. The engine reaches that memory through a simple word port: a request is held until an acknowledge arrives. It prefetches the next descriptor. It accepts an incoming frame when the frame's length is announced. It then either hands the buffer address and length to the write-DMA side, or drops the frame because it is too large. In both cases it finally returns the descriptor to the host with a status word.

Ring wrap comes from an end-of-ring flag inside each descriptor, not from a programmed count. When the engine meets a descriptor that the host still owns, it raises a one-cycle descriptor-unavailable interrupt and stops reception. Reception resumes on a restart strobe, or when receive enable goes low and then high again. In both cases the engine fetches again from the same ring position. Moving frame data, CRC checking and address filtering are done elsewhere.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset the engine requests no memory access, does not accept a frame, raises no interrupt and gives no DMA start. Its first descriptor fetch reads word 0 at the ring base address.
- R2: A fetch reads word 0 at `base + 16*index`. Only when bit 31 (owned by controller) of word 0 is 1 does it go on to read word 2 (offset 8, buffer address low half) and then word 3 (offset 12, high half). Word 1 (offset 4) is never read. Bits 7:0 of `ring_base` are ignored.
- R3: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is seen.
- R4: `frm_ready` is high only while a fetched descriptor is held and `rx_en` is high. A frame is accepted when it is high together with `frm_valid`. A frame that passes the size rule gives a one-cycle `dma_start` with `dma_addr` = {word 3, word 2} and `dma_len` = `frm_len`.
- R5: A frame is dropped, with no `dma_start`, when `max_len` is 0, when `frm_len > max_len`, or when `frm_len` exceeds the buffer length in word 0 bits 13:0. Its write-back sets bit 21.
- R6: A frame of 8192 bytes or more sets bit 20 in its write-back. This does not cause a drop by itself, so such a frame is still transferred if it passes R5.
- R7: After `dma_done`, or right away for a dropped frame, word 0 of the same descriptor is written. Bit 31 is 0, bit 30 is a copy of the fetched end-of-ring flag, bits 13:0 hold `frm_len`, bits 21/20 hold the R5/R6 flags, and every other bit is 0.
- R8: After the write-back the index advances by one. If the completed descriptor had bit 30 (end of ring) set, the index returns to 0 instead.
- R9: A fetched word 0 with bit 31 clear gives exactly one cycle of `rdu_irq`. After that no memory request is made and `frm_ready` stays low until a restart.
- R10: A `restart` pulse, or `rx_en` going low and then high, ends the halt. The next fetch reads word 0 at the index where the halt happened.
- R11: While `rx_en` is low, no new fetch starts. A descriptor that has been fetched but not yet used is given up and fetched again when `rx_en` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| restart | input | 1 | One-cycle strobe that ends a descriptor-unavailable halt |
| ring_base | input | ADDR_W | Ring start address (bits 7:0 ignored) |
| max_len | input | LEN_W | Largest accepted frame length, 0 rejects all |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| frm_valid | input | 1 | A frame waits, length on `frm_len` |
| frm_len | input | LEN_W | Frame length in bytes |
| frm_ready | output | 1 | Frame can be accepted this cycle |
| dma_start | output | 1 | One-cycle start for the write-DMA side |
| dma_addr | output | ADDR_W | Buffer address for the DMA |
| dma_len | output | LEN_W | Byte count for the DMA |
| dma_done | input | 1 | DMA finished the frame |
| rdu_irq | output | 1 | Descriptor-unavailable interrupt pulse |

## Verification
Every cycle, the assertions check these rules: memory requests stay stable while waiting for an acknowledge, word 1 is never read, every write-back has the ownership bit clear, no DMA start breaks the length limit, and the halt after an interrupt makes no further requests. Other behaviour only shows up across whole scenarios driven by the bench: the ring position advancing and wrapping on the end-of-ring flag, the exact status word written back for accepted, dropped and long frames, and fetching again from the same position after a restart strobe or an enable toggle.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    // descriptor geometry
    localparam int DESC_SHIFT = 4;

    // word 0 field positions
    localparam int OWN_BIT  = 31;
    localparam int EOR_BIT  = 30;
    localparam int SERR_BIT = 21;
    localparam int LERR_BIT = 20;

    // word selectors inside a descriptor
    localparam logic [1:0] W_CMD = 2'd0;
    localparam logic [1:0] W_LO  = 2'd2;
    localparam logic [1:0] W_HI  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CMD,
        ST_RD_LO,
        ST_RD_HI,
        ST_READY,
        ST_XFER,
        ST_WB
    } rxd_state_e;

endpackage

// File: rtl/rxd_index_ctr.sv
module rxd_index_ctr #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            if (wrap) idx_d = '0;
            else      idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

endmodule

// File: rtl/rxd_addr_gen.sv
module rxd_addr_gen
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        word,
    output logic [ADDR_W-1:0] addr
);

    localparam int PAD_IDX  = ADDR_W - IDX_W - DESC_SHIFT;
    localparam int PAD_WORD = ADDR_W - 4;

    logic [ADDR_W-1:0] base_al;
    logic [ADDR_W-1:0] desc_off;
    logic [ADDR_W-1:0] word_off;

    always_comb begin
        base_al  = {base[ADDR_W-1:8], 8'h00};
        desc_off = {{PAD_IDX{1'b0}}, idx, {DESC_SHIFT{1'b0}}};
        word_off = {{PAD_WORD{1'b0}}, word, 2'b00};
        addr     = base_al + desc_off + word_off;
    end

endmodule

// File: rtl/rxd_len_check.sv
module rxd_len_check #(
    parameter int LEN_W    = 14,
    parameter int LONG_LEN = 8192
) (
    input  logic [LEN_W-1:0] frm_len,
    input  logic [LEN_W-1:0] max_len,
    input  logic [LEN_W-1:0] buf_len,
    output logic             size_err,
    output logic             long_err
);

    localparam logic [LEN_W-1:0] LONG_L = LEN_W'(LONG_LEN);

    logic over_max;
    logic over_buf;
    logic no_max;

    always_comb begin
        no_max   = (max_len == '0);
        over_max = (frm_len > max_len);
        over_buf = (frm_len > buf_len);
        size_err = no_max | over_max | over_buf;
        long_err = (frm_len >= LONG_L);
    end

endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine
    import rxd_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int MAX_DESC = 1024,
    parameter int LEN_W    = 14,
    parameter int LONG_LEN = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              restart,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LEN_W-1:0]  max_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    output logic              frm_ready,
    output logic              dma_start,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    output logic              rdu_irq
);

    localparam int IDX_W = $clog2(MAX_DESC);

    typedef struct packed {
        rxd_state_e       st;
        logic             halted;
        logic             eor;
        logic [LEN_W-1:0] blen;
        logic [31:0]      blo;
        logic [31:0]      bhi;
        logic [LEN_W-1:0] flen;
        logic             serr;
        logic             lerr;
        logic             dma_go;
        logic             irq;
    } rxd_regs_t;

    rxd_regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic             adv;
    logic [1:0]       word_sel;
    logic             chk_serr;
    logic             chk_lerr;

    rxd_index_ctr #(.IDX_W(IDX_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .wrap  (r_q.eor),
        .idx   (idx)
    );

    rxd_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
        .base (ring_base),
        .idx  (idx),
        .word (word_sel),
        .addr (mem_addr)
    );

    rxd_len_check #(.LEN_W(LEN_W), .LONG_LEN(LONG_LEN)) u_len (
        .frm_len  (frm_len),
        .max_len  (max_len),
        .buf_len  (r_q.blen),
        .size_err (chk_serr),
        .long_err (chk_lerr)
    );

    always_comb begin
        r_d        = r_q;
        r_d.dma_go = 1'b0;
        r_d.irq    = 1'b0;
        adv        = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        word_sel   = W_CMD;
        mem_wdata  = '0;
        frm_ready  = 1'b0;

        if (restart || !rx_en) r_d.halted = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (rx_en && !r_q.halted) r_d.st = ST_RD_CMD;
            end
            ST_RD_CMD: begin
                mem_req  = 1'b1;
                word_sel = W_CMD;
                if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        r_d.eor  = mem_rdata[EOR_BIT];
                        r_d.blen = mem_rdata[LEN_W-1:0];
                        r_d.st   = ST_RD_LO;
                    end else begin
                        r_d.irq    = 1'b1;
                        r_d.halted = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                end
            end
            ST_RD_LO: begin
                mem_req  = 1'b1;
                word_sel = W_LO;
                if (mem_ack) begin
                    r_d.blo = mem_rdata;
                    r_d.st  = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                mem_req  = 1'b1;
                word_sel = W_HI;
                if (mem_ack) begin
                    r_d.bhi = mem_rdata;
                    r_d.st  = ST_READY;
                end
            end
            ST_READY: begin
                frm_ready = rx_en;
                if (!rx_en) begin
                    r_d.st = ST_IDLE;
                end else if (frm_valid) begin
                    r_d.flen = frm_len;
                    r_d.serr = chk_serr;
                    r_d.lerr = chk_lerr;
                    if (chk_serr) begin
                        r_d.st = ST_WB;
                    end else begin
                        r_d.dma_go = 1'b1;
                        r_d.st     = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (dma_done) r_d.st = ST_WB;
            end
            ST_WB: begin
                mem_req                  = 1'b1;
                mem_we                   = 1'b1;
                word_sel                 = W_CMD;
                mem_wdata[EOR_BIT]       = r_q.eor;
                mem_wdata[SERR_BIT]      = r_q.serr;
                mem_wdata[LERR_BIT]      = r_q.lerr;
                mem_wdata[LEN_W-1:0]     = r_q.flen;
                if (mem_ack) begin
                    adv    = 1'b1;
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dma_start = r_q.dma_go;
    assign dma_addr  = ADDR_W'({r_q.bhi, r_q.blo});
    assign dma_len   = r_q.flen;
    assign rdu_irq   = r_q.irq;

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R2
    word_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> mem_addr[3:2] != 2'b01 && mem_addr[1:0] == 2'b00);

    // R7
    wb_own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[OWN_BIT] && mem_addr[3:0] == 4'h0);

    // R9
    rdu_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdu_irq |=> !mem_req && !frm_ready && !rdu_irq);

    // R4
    dma_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> dma_len <= max_len && max_len != '0);

    // R4
    dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start && !mem_req);

endmodule

// File: tb/sim_rxd_ring_engine.sv
module sim_rxd_ring_engine;

    localparam int          NDESC = 6;
    localparam logic [63:0] BASE  = 64'h0000_0001_2345_6700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        restart = 1'b0;
    logic [63:0] ring_base = BASE | 64'h3C;
    logic [13:0] max_len = 14'd1518;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;
    logic        frm_valid = 1'b0;
    logic [13:0] frm_len = '0;
    logic        frm_ready, dma_start, dma_done = 1'b0, rdu_irq;
    logic [63:0] dma_addr;
    logic [13:0] dma_len;

    always #10 clk = ~clk;

    rxd_ring_engine u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .restart(restart),
        .ring_base(ring_base), .max_len(max_len),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
        .dma_start(dma_start), .dma_addr(dma_addr), .dma_len(dma_len),
        .dma_done(dma_done), .rdu_irq(rdu_irq)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] dmem [NDESC*4];

    int          rd_cnt = 0, wb_cnt = 0, rdu_cnt = 0, dma_cnt = 0;
    logic [63:0] last_rd_addr = '0, wb_addr = '0, dma_addr_seen = '0, held_addr = '0;
    logic [31:0] wb_data = '0;
    logic [13:0] dma_len_seen = '0;
    logic        pend = 1'b0, rdu_prev = 1'b0;
    int          lat = 0, dma_wait = -1;
    int          m_idx = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_wb(input logic eor, input logic [13:0] len,
                                           input logic serr, input logic lerr);
        logic [31:0] w = '0;
        w[30] = eor; w[21] = serr; w[20] = lerr; w[13:0] = len;
        return w;
    endfunction

    function automatic logic size_bad(input logic [13:0] len, input logic [13:0] mx, input logic [13:0] bl);
        return (mx == 14'd0) || (len > mx) || (len > bl);
    endfunction

    task automatic arm(input int i, input logic [13:0] blen, input logic own);
        dmem[i*4]   = {own, (i == NDESC-1), 16'h0000, blen};
        dmem[i*4+1] = $urandom;
        dmem[i*4+2] = 32'h8000_0000 + 32'(i) * 32'h1000;
        dmem[i*4+3] = 32'h0000_00A0 + 32'(i);
    endtask

    // memory responder with random latency (R2, R3 observed at the port)
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            pend    <= 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend      <= 1'b1;
                held_addr <= mem_addr;
                lat       <= int'($urandom % 3);
            end else begin
                chk(mem_addr == held_addr, "R3 address held", mem_addr, held_addr);
                if (lat == 0) begin
                    logic [63:0] off;
                    off = mem_addr - BASE;
                    if (off >= 64'(NDESC*16)) begin
                        chk(1'b0, "R2 address in ring", mem_addr, BASE);
                    end else begin
                        if (mem_we) begin
                            dmem[int'(off >> 2)] = mem_wdata;
                            wb_addr <= mem_addr;
                            wb_data <= mem_wdata;
                            wb_cnt  <= wb_cnt + 1;
                        end else begin
                            if (off[3:2] == 2'b01) chk(1'b0, "R2 word1 never read", mem_addr, 0);
                            mem_rdata    <= dmem[int'(off >> 2)];
                            last_rd_addr <= mem_addr;
                            rd_cnt       <= rd_cnt + 1;
                        end
                    end
                    mem_ack <= 1'b1;
                end else begin
                    lat <= lat - 1;
                end
            end
        end
    end

    // DMA responder and interrupt monitor
    always @(negedge clk) begin
        if (dma_done) dma_done <= 1'b0;
        if (dma_start) begin
            dma_cnt       <= dma_cnt + 1;
            dma_addr_seen <= dma_addr;
            dma_len_seen  <= dma_len;
            dma_wait      <= int'($urandom % 4);
        end else if (dma_wait == 0) begin
            dma_done <= 1'b1;
            dma_wait <= -1;
        end else if (dma_wait > 0) begin
            dma_wait <= dma_wait - 1;
        end
        if (rst_n && rdu_irq) begin
            rdu_cnt <= rdu_cnt + 1;
            if (rdu_prev) chk(1'b0, "R9 single-cycle irq", 2, 1);
        end
        rdu_prev <= rdu_irq;
    end

    task automatic run_frame(input logic [13:0] len, input logic [13:0] next_blen);
        logic [31:0] w0;
        logic        serr, lerr;
        int          wbc, dc, t;
        w0   = dmem[m_idx*4];
        serr = size_bad(len, max_len, w0[13:0]);
        lerr = (len >= 14'd8192);
        wbc  = wb_cnt;
        dc   = dma_cnt;
        frm_len   = len;
        frm_valid = 1'b1;
        t = 0;
        while (!frm_ready && t < 300) begin @(negedge clk); t++; end
        chk(frm_ready, "R4 frame accepted", 0, 1);
        @(negedge clk);
        frm_valid = 1'b0;
        t = 0;
        while (wb_cnt == wbc && t < 3000) begin @(negedge clk); t++; end
        chk(wb_cnt == wbc + 1, "R7 write-back done", 64'(wb_cnt), 64'(wbc + 1));
        chk(wb_addr == BASE + 64'(m_idx * 16), "R8 write-back index", wb_addr, BASE + 64'(m_idx * 16));
        chk(wb_data == exp_wb(w0[30], len, serr, lerr), serr ? "R5 drop status" : (lerr ? "R6 long status" : "R7 status word"),
            64'(wb_data), 64'(exp_wb(w0[30], len, serr, lerr)));
        if (serr) begin
            chk(dma_cnt == dc, "R5 no dma on drop", 64'(dma_cnt), 64'(dc));
        end else begin
            chk(dma_cnt == dc + 1, "R4 one dma start", 64'(dma_cnt), 64'(dc + 1));
            chk(dma_addr_seen == {dmem[m_idx*4+3], dmem[m_idx*4+2]}, "R4 dma address",
                dma_addr_seen, {dmem[m_idx*4+3], dmem[m_idx*4+2]});
            chk(dma_len_seen == len, "R4 dma length", 64'(dma_len_seen), 64'(len));
        end
        arm(m_idx, next_blen, 1'b1);
        m_idx = w0[30] ? 0 : m_idx + 1;
    endtask

    // pause reception (R11), optionally patch the current descriptor, resume
    task automatic pause_resume(input logic [13:0] blen, input logic own);
        int rdc;
        rx_en = 1'b0;
        repeat (30) @(negedge clk);
        rdc = rd_cnt;
        repeat (20) @(negedge clk);
        chk(rd_cnt == rdc && !frm_ready, "R11 no fetch while disabled", 64'(rd_cnt), 64'(rdc));
        arm(m_idx, blen, own);
        rx_en = 1'b1;
    endtask

    task automatic halt_here();
        int r0, rdc, t;
        logic saw_ready;
        r0 = rdu_cnt;
        pause_resume(14'd1600, 1'b0);
        t = 0;
        while (rdu_cnt == r0 && t < 200) begin @(negedge clk); t++; end
        chk(rdu_cnt == r0 + 1, "R9 interrupt raised", 64'(rdu_cnt), 64'(r0 + 1));
        rdc = rd_cnt;
        saw_ready = 1'b0;
        frm_valid = 1'b1;
        frm_len   = 14'd64;
        repeat (40) begin @(negedge clk); if (frm_ready) saw_ready = 1'b1; end
        frm_valid = 1'b0;
        chk(rd_cnt == rdc && !saw_ready, "R9 halted", 64'(rd_cnt), 64'(rdc));
        dmem[m_idx*4][31] = 1'b1;
    endtask

    task automatic wait_refetch();
        int rdc, t;
        rdc = rd_cnt;
        t = 0;
        while (rd_cnt == rdc && t < 200) begin @(negedge clk); t++; end
        chk(last_rd_addr == BASE + 64'(m_idx * 16), "R10 refetch same index",
            last_rd_addr, BASE + 64'(m_idx * 16));
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin @(posedge clk); cyc++; end
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [13:0] ln, mx;
        void'($urandom(32'd2024));
        for (int i = 0; i < NDESC; i++) arm(i, 14'd1600, 1'b1);
        repeat (3) @(negedge clk);
        chk(!mem_req && !frm_ready && !rdu_irq && !dma_start, "R1 reset outputs", 64'(mem_req), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!mem_req && rd_cnt == 0, "R11 idle while disabled", 64'(rd_cnt), 0);
        rx_en = 1'b1;
        begin
            int t = 0;
            while (rd_cnt == 0 && t < 100) begin @(negedge clk); t++; end
        end
        chk(last_rd_addr == BASE, "R1 first fetch at base (R2 low bits ignored)", last_rd_addr, BASE);

        // directed frames around the limits
        run_frame(14'd64, 14'd1600);
        run_frame(14'd1518, 14'd1600);
        run_frame(14'd1519, 14'd1600);
        pause_resume(14'd100, 1'b1);
        run_frame(14'd101, 14'd1600);
        pause_resume(14'd100, 1'b1);
        run_frame(14'd100, 14'd1600);
        run_frame(14'd60, 14'd1600);   // wraps after end-of-ring descriptor (R8)
        chk(m_idx == 0, "R8 wrap on end-of-ring flag", 64'(m_idx), 0);
        max_len = 14'd0;
        run_frame(14'd60, 14'd1600);
        run_frame(14'd0, 14'd16383);

        // long frames
        max_len = 14'h3FFF;
        pause_resume(14'h3FFF, 1'b1);
        run_frame(14'd8191, 14'h3FFF);
        run_frame(14'd8192, 14'h3FFF);
        run_frame(14'd12000, 14'd1600);
        max_len = 14'd9000;
        pause_resume(14'h3FFF, 1'b1);
        run_frame(14'd9001, 14'd1600);

        // halt and restart by strobe
        max_len = 14'd1518;
        halt_here();
        @(negedge clk); restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        wait_refetch();
        run_frame(14'd200, 14'd1600);

        // halt and restart by enable toggle
        halt_here();
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        wait_refetch();
        run_frame(14'd300, 14'd1600);

        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            mx = 14'd1518;
            case ($urandom % 4)
                0: ln = 14'($urandom % 1519);
                1: ln = mx + 14'($urandom % 2);
                2: ln = dmem[m_idx*4][13:0] + 14'($urandom % 2);
                default: ln = 14'($urandom % 2048);
            endcase
            max_len = mx;
            run_frame(ln, 14'(64 + ($urandom % 1984)));
        end

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule